// File: doc/BRIEF.md
# Label Acceptance Bitmap

This block holds one enable bit for every value an 8-bit word label can take, 256 entries by default, in any mix of set and cleared. A receive path shows it the label of each incoming word and gets back at once, in the same cycle, whether that word is to be kept or dropped. A host-side command path changes the table in several ways. It can clear every entry, set every entry, or clear or set one addressed entry. A serial stream can also write or read the whole table one bit per step.

The serial walk always starts at the top address (all ones) and moves down by one address per step. While the stream select input is high, each step either writes the input bit into the current entry or only moves on, so the entry's value can be read out. When select drops, the walk returns to the top address. A stream that stops early therefore leaves the entries it did not reach unchanged. Two lookup options are provided. Filtering can be switched off, and then every label is accepted. The label's bit order can be reversed before it indexes the table.

Top module: `lbl_accept_map`

## Requirements
- R1: After reset every entry reads 0 and the serial walk points at address 0xFF.
- R2: A command with `cmd_op` = 1 (clear all) makes every entry 0 from the next cycle on.
- R3: A command with `cmd_op` = 2 (set all) makes every entry 1 from the next cycle on.
- R4: A command with `cmd_op` = 3 clears only the entry at `cmd_addr`. All other entries keep their values.
- R5: A command with `cmd_op` = 4 sets only the entry at `cmd_addr`. All other entries keep their values.
- R6: While `strm_sel` is high, each cycle with `strm_step`=1 and `strm_wr`=1 writes `strm_din` into the entry at the walk pointer. The pointer starts at 0xFF and decreases by one per step. After 0x00 it wraps to 0xFF. It returns to 0xFF whenever `strm_sel` is low. Example: a stream 1,0,1,1 sets 0xFF, clears 0xFE, sets 0xFD and sets 0xFC.
- R7: `strm_dout` shows, in the same cycle, the entry at the walk pointer. A step with `strm_wr`=0 moves the pointer and writes nothing, so a 256-step read returns the table from 0xFF down to 0x00.
- R8: If `strm_sel` drops before all 256 steps have been taken, the entries not yet reached keep their previous values.
- R9: With `filt_en`=1 and `rev_order`=0, `lk_hit` equals, in the same cycle, the entry at `lk_label`.
- R10: With `filt_en`=0, `lk_hit` is 1 for every label, whatever the table holds.
- R11: With `rev_order`=1, the table index is `lk_label` with its bits reversed, so label bit 0 becomes index bit 7.
- R12: In a cycle with both a table command (codes 1 to 4) and a stream write, the command is applied and the stream bit is dropped. The walk pointer still steps.
- R13: Commands with `cmd_op` equal to 0, 5, 6 or 7 leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code (1 clear all, 2 set all, 3 clear one, 4 set one) |
| cmd_addr | input | 8 | Entry address for the single-entry commands |
| strm_sel | input | 1 | Serial walk active; low returns the pointer to 0xFF |
| strm_step | input | 1 | Advance the walk by one entry |
| strm_wr | input | 1 | 1: the step writes `strm_din`; 0: the step only reads |
| strm_din | input | 1 | Serial bit to write |
| strm_dout | output | 1 | Entry at the current walk pointer |
| lk_label | input | 8 | Label of the word being checked |
| filt_en | input | 1 | 1: use the table; 0: accept every label |
| rev_order | input | 1 | Reverse the label's bit order before the lookup |
| lk_hit | output | 1 | Word accepted |

## Verification
`lk_hit` and `strm_dout` are combinational, so they are due in the same cycle as the label, option or pointer that selects them. Table commands and stream writes appear one cycle later, after one register stage. The bench drives inputs just after a rising edge and compares results at the following falling edge. A table change is checked only through lookups or a readback started in a later cycle. The walk pointer moves one step per rising edge, so the bench predicts each bit of a readback as entry 0xFF minus the number of steps already taken.

// File: rtl/lblmap_pkg.sv
package lblmap_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_CLR_ALL = 3'd1,
    OP_SET_ALL = 3'd2,
    OP_CLR_ONE = 3'd3,
    OP_SET_ONE = 3'd4
  } map_op_e;

  localparam int unsigned OP_W = 3;

endpackage

// File: rtl/lblmap_walker.sv
module lblmap_walker #(
  parameter int unsigned LABEL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               walk_sel,
  input  logic               walk_step,
  output logic [LABEL_W-1:0] walk_ptr
);

  localparam logic [LABEL_W-1:0] TOP_ADDR = {LABEL_W{1'b1}};

  function automatic logic [LABEL_W-1:0] step_down(input logic [LABEL_W-1:0] p);
    return p - 1'b1;
  endfunction

  logic advance;
  assign advance = walk_sel && walk_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         walk_ptr <= TOP_ADDR;
    else if (!walk_sel) walk_ptr <= TOP_ADDR;
    else if (advance)   walk_ptr <= step_down(walk_ptr);
  end

  // R6: the walk goes back to the top address while select is low
  assert_ptr_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_sel |=> walk_ptr == TOP_ADDR);

  // R6: each step moves the pointer down by exactly one, wrapping after zero
  assert_ptr_descend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> walk_ptr == LABEL_W'($past(walk_ptr) - 1'b1));

  // R6: without a step the pointer holds while select stays high
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    walk_sel && !walk_step |=> walk_ptr == $past(walk_ptr));

endmodule

// File: rtl/lblmap_store.sv
module lblmap_store
  import lblmap_pkg::*;
#(
  parameter int unsigned LABEL_W = 8,
  parameter int unsigned DEPTH   = 1 << LABEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [OP_W-1:0]    cmd_op,
  input  logic [LABEL_W-1:0] cmd_addr,
  input  logic               wr_req,
  input  logic [LABEL_W-1:0] wr_ptr,
  input  logic               wr_bit,
  output logic [DEPTH-1:0]   map_q
);

  // Named command events, shared by the update logic and the assertions
  logic cmd_clr_all, cmd_set_all, cmd_clr_one, cmd_set_one, cmd_known, strm_wr_go;
  assign cmd_clr_all = cmd_valid && (cmd_op == OP_CLR_ALL);
  assign cmd_set_all = cmd_valid && (cmd_op == OP_SET_ALL);
  assign cmd_clr_one = cmd_valid && (cmd_op == OP_CLR_ONE);
  assign cmd_set_one = cmd_valid && (cmd_op == OP_SET_ONE);
  assign cmd_known   = cmd_clr_all || cmd_set_all || cmd_clr_one || cmd_set_one;
  // R12: a table command wins over a stream write in the same cycle
  assign strm_wr_go  = wr_req && !cmd_known;

  logic [DEPTH-1:0] map_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit_cmd, hit_wr;
    assign hit_cmd = (cmd_addr == LABEL_W'(i));
    assign hit_wr  = (wr_ptr == LABEL_W'(i));
    assign map_d[i] = cmd_clr_all               ? 1'b0 :
                      cmd_set_all               ? 1'b1 :
                      (cmd_clr_one && hit_cmd)  ? 1'b0 :
                      (cmd_set_one && hit_cmd)  ? 1'b1 :
                      (strm_wr_go && hit_wr)    ? wr_bit :
                                                  map_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  assert_clear_all_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_all |=> map_q == '0);

  assert_set_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set_all |=> &map_q);

  assert_clear_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_one |=> !map_q[$past(cmd_addr)]);

  assert_set_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set_one |=> map_q[$past(cmd_addr)]);

  assert_stream_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strm_wr_go |=> map_q[$past(wr_ptr)] == $past(wr_bit));

  assert_unknown_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_known && !wr_req |=> $stable(map_q));

endmodule

// File: rtl/lblmap_lookup.sv
module lblmap_lookup #(
  parameter int unsigned LABEL_W = 8,
  parameter int unsigned DEPTH   = 1 << LABEL_W
) (
  input  logic [DEPTH-1:0]   map_q,
  input  logic [LABEL_W-1:0] lk_label,
  input  logic               filt_en,
  input  logic               rev_order,
  output logic               lk_hit
);

  function automatic logic [LABEL_W-1:0] flip_bits(input logic [LABEL_W-1:0] v);
    logic [LABEL_W-1:0] r;
    for (int b = 0; b < LABEL_W; b++) r[b] = v[LABEL_W-1-b];
    return r;
  endfunction

  logic [LABEL_W-1:0] key;
  logic               entry_bit;

  // R11: optional bit reversal ahead of the table index
  assign key       = rev_order ? flip_bits(lk_label) : lk_label;
  // R9: the enable bit selected by the label, combinational
  assign entry_bit = map_q[key];
  assign lk_hit    = !filt_en || entry_bit;

  always_comb begin
    if (filt_en === 1'b0) begin
      assert_pass_all_R10: assert (lk_hit === 1'b1);
    end
  end

endmodule

// File: rtl/lbl_accept_map.sv
module lbl_accept_map
  import lblmap_pkg::*;
#(
  parameter int unsigned LABEL_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd_op,
  input  logic [LABEL_W-1:0] cmd_addr,
  input  logic               strm_sel,
  input  logic               strm_step,
  input  logic               strm_wr,
  input  logic               strm_din,
  output logic               strm_dout,
  input  logic [LABEL_W-1:0] lk_label,
  input  logic               filt_en,
  input  logic               rev_order,
  output logic               lk_hit
);

  localparam int unsigned DEPTH = 1 << LABEL_W;

  logic [LABEL_W-1:0] walk_ptr;
  logic [DEPTH-1:0]   map_q;
  logic               wr_req;
  logic               rd_step;

  assign wr_req  = strm_sel && strm_step && strm_wr;
  assign rd_step = strm_sel && strm_step && !strm_wr;

  lblmap_walker #(.LABEL_W(LABEL_W)) i_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .walk_sel  (strm_sel),
    .walk_step (strm_step),
    .walk_ptr  (walk_ptr)
  );

  lblmap_store #(.LABEL_W(LABEL_W), .DEPTH(DEPTH)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .wr_req    (wr_req),
    .wr_ptr    (walk_ptr),
    .wr_bit    (strm_din),
    .map_q     (map_q)
  );

  lblmap_lookup #(.LABEL_W(LABEL_W), .DEPTH(DEPTH)) i_lookup (
    .map_q     (map_q),
    .lk_label  (lk_label),
    .filt_en   (filt_en),
    .rev_order (rev_order),
    .lk_hit    (lk_hit)
  );

  // R7: readback bit of the entry under the walk pointer
  assign strm_dout = map_q[walk_ptr];

  // R7: a read step with no command leaves the table as it was
  assert_read_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_step && !cmd_valid |=> $stable(map_q));

endmodule

// File: tb/test_lbl_accept_map.sv
module test_lbl_accept_map;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_addr = 8'd0;
  logic       strm_sel = 1'b0, strm_step = 1'b0, strm_wr = 1'b0, strm_din = 1'b0;
  logic       strm_dout;
  logic [7:0] lk_label = 8'd0;
  logic       filt_en = 1'b1, rev_order = 1'b0;
  logic       lk_hit;

  always #5 clk = ~clk;

  lbl_accept_map i_lbl_accept_map (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .strm_sel(strm_sel), .strm_step(strm_step), .strm_wr(strm_wr), .strm_din(strm_din),
    .strm_dout(strm_dout), .lk_label(lk_label), .filt_en(filt_en), .rev_order(rev_order),
    .lk_hit(lk_hit)
  );

  typedef struct {
    string tag;
    logic  val;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic obs_en = 1'b0;
  logic obs_sel = 1'b0;   // 0: strm_dout, 1: lk_hit
  logic model [256];
  bit   finished = 0;

  // Monitor: pops the expected item and compares at the falling edge
  always @(negedge clk) begin
    if (obs_en) begin
      exp_t e;
      logic got;
      e = exp_q.pop_front();
      got = obs_sel ? lk_hit : strm_dout;
      checks++;
      if (got !== e.val) begin
        errors++;
        $display("FAIL %s: got %b expected %b", e.tag, got, e.val);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_bit(input logic sel, input string tag, input logic val);
    exp_t e;
    e.tag = tag;
    e.val = val;
    exp_q.push_back(e);
    obs_sel = sel;
    obs_en = 1'b1;
    cyc();
    obs_en = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [7:0] addr);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_addr = addr;
    case (op)
      3'd1: for (int k = 0; k < 256; k++) model[k] = 1'b0;
      3'd2: for (int k = 0; k < 256; k++) model[k] = 1'b1;
      3'd3: model[addr] = 1'b0;
      3'd4: model[addr] = 1'b1;
      default: ;
    endcase
    cyc();
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
  endtask

  // Bit i of the stream is v[i % 256], inverted on the second lap
  task automatic load_vec(input int n, input logic [255:0] v);
    strm_sel = 1'b1;
    strm_wr = 1'b1;
    strm_step = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic b;
      b = v[i % 256] ^ (i >= 256);
      strm_din = b;
      model[255 - (i % 256)] = b;
      cyc();
    end
    strm_step = 1'b0;
    strm_sel = 1'b0;
    strm_wr = 1'b0;
    cyc();
  endtask

  task automatic readback_all(input string tag);
    strm_sel = 1'b1;
    strm_wr = 1'b0;
    strm_step = 1'b1;
    for (int i = 0; i < 256; i++) expect_bit(1'b0, tag, model[255 - i]);
    strm_step = 1'b0;
    strm_sel = 1'b0;
    cyc();
  endtask

  task automatic look(input logic [7:0] lbl, input logic fe, input logic rv,
                      input logic val, input string tag);
    lk_label = lbl;
    filt_en = fe;
    rev_order = rv;
    expect_bit(1'b1, tag, val);
    filt_en = 1'b1;
    rev_order = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 256; k++) model[k] = 1'b0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1: reset state, full readback starting at 0xFF
    readback_all("R1");
    look(8'h00, 1'b1, 1'b0, 1'b0, "R1");

    // R3: set all
    do_cmd(3'd2, 8'h00);
    look(8'h5A, 1'b1, 1'b0, 1'b1, "R3");
    readback_all("R3");

    // R6 and R8: short stream 1,0,1,1 then select dropped
    load_vec(4, 256'b1101);
    look(8'hFF, 1'b1, 1'b0, 1'b1, "R6");
    look(8'hFE, 1'b1, 1'b0, 1'b0, "R6");
    look(8'hFD, 1'b1, 1'b0, 1'b1, "R6");
    look(8'hFC, 1'b1, 1'b0, 1'b1, "R6");
    look(8'hFB, 1'b1, 1'b0, 1'b1, "R8");
    readback_all("R8");

    // R2: clear all
    do_cmd(3'd1, 8'h00);
    readback_all("R2");

    // R5: set single entries
    do_cmd(3'd4, 8'h01);
    do_cmd(3'd4, 8'h37);
    look(8'h01, 1'b1, 1'b0, 1'b1, "R5");
    look(8'h00, 1'b1, 1'b0, 1'b0, "R5");
    look(8'h38, 1'b1, 1'b0, 1'b0, "R5");

    // R11: reversed bit order
    look(8'h80, 1'b1, 1'b1, 1'b1, "R11");
    look(8'h80, 1'b1, 1'b0, 1'b0, "R11");
    look(8'hEC, 1'b1, 1'b1, 1'b1, "R11");
    look(8'h37, 1'b1, 1'b1, 1'b0, "R11");

    // R10: filtering off accepts everything
    look(8'h42, 1'b0, 1'b0, 1'b1, "R10");
    look(8'h42, 1'b0, 1'b1, 1'b1, "R10");

    // R4: clear one entry, neighbour untouched
    do_cmd(3'd3, 8'h37);
    look(8'h37, 1'b1, 1'b0, 1'b0, "R4");
    look(8'h01, 1'b1, 1'b0, 1'b1, "R4");

    // R13: undefined and no-op codes leave the table alone
    do_cmd(3'd0, 8'h00);
    do_cmd(3'd5, 8'h01);
    do_cmd(3'd6, 8'h02);
    do_cmd(3'd7, 8'h00);
    look(8'h01, 1'b1, 1'b0, 1'b1, "R13");
    look(8'h00, 1'b1, 1'b0, 1'b0, "R13");
    look(8'h02, 1'b1, 1'b0, 1'b0, "R13");

    // R7 and R9: full pattern load then readback and lookups
    load_vec(256, {8{32'hA5C3_96E1}});
    readback_all("R7");
    readback_all("R7");
    look(8'h10, 1'b1, 1'b0, model[8'h10], "R9");
    look(8'hC4, 1'b1, 1'b0, model[8'hC4], "R9");
    look(8'h00, 1'b1, 1'b0, model[8'h00], "R9");
    look(8'hFF, 1'b1, 1'b0, model[8'hFF], "R9");

    // R6: wrap after 0x00, the 257th bit lands in 0xFF again
    load_vec(257, {8{32'h3C5A_0FF1}});
    readback_all("R6");

    // R12: command and stream write in one cycle
    do_cmd(3'd1, 8'h00);
    strm_sel = 1'b1;
    strm_wr = 1'b1;
    strm_step = 1'b1;
    strm_din = 1'b0;
    cmd_valid = 1'b1;
    cmd_op = 3'd2;
    for (int k = 0; k < 256; k++) model[k] = 1'b1;
    cyc();
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
    strm_din = 1'b0;
    model[8'hFE] = 1'b0;
    cyc();
    strm_step = 1'b0;
    strm_sel = 1'b0;
    strm_wr = 1'b0;
    cyc();
    look(8'hFF, 1'b1, 1'b0, 1'b1, "R12");
    look(8'hFE, 1'b1, 1'b0, 1'b0, "R12");
    readback_all("R12");

    cyc();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule